// File: doc/BRIEF.md
# Privileged Return and Environment Trap Unit

This unit executes the system instructions that leave a trap handler or enter one on purpose. It handles the four trap-return instructions (one each for the user, supervisor, hypervisor and machine levels), the environment call and the breakpoint. For each instruction word, the unit is given the current privilege, the status register, the four saved exception PCs and an external-interrupt-pending flag. From these it produces the new status value, the new privilege, the next PC, and an exception or interrupt request with a cause code.

The unit is one registered stage. A request presented with `in_valid` high produces its result on the outputs on the following clock edge, and `out_valid` marks that result. Two jobs are left to the surrounding core: vectoring to a handler when `trap_req` is high, and storing the status and exception-PC registers. Privilege is encoded U=0, S=1, H=2, M=3. The status register layout is as follows:
- Interrupt-enable bits: UIE bit 0, SIE bit 1, HIE bit 2, MIE bit 3.
- Previous-enable bits: UPIE bit 4, SPIE bit 5, HPIE bit 6, MPIE bit 7.
- Previous-mode fields: SPP bit 8, HPP bits 10:9, MPP bits 12:11.

Top module: `sys_ret_trap_unit`

## Requirements
- R1: The recognised encodings are 0x00200073 (user return), 0x10200073 (supervisor return), 0x20200073 (hypervisor return), 0x30200073 (machine return), 0x00000073 (environment call) and 0x00100073 (breakpoint). For these, `sys_hit` is 1. Any other word gives `sys_hit`=0, `npc`=PC+4, unchanged status and privilege, and no request.
- R2: A return whose level (bits 29:28 of the word) differs from the current privilege raises an exception with cause 2 (`trap_irq`=0). In that case `status_out` equals `status_in`, `prv_out` equals the current privilege, and `npc` equals PC.
- R3: For every return, `epc_addr` is (level << 8) + 0x41, that is 0x041, 0x141, 0x241 or 0x341. For any non-return word it is 0. A legal return sets `npc` to the exception PC held at that address (U, S, H, M respectively).
- R4: A legal supervisor, hypervisor or machine return makes these changes:
  - The level's enable bit takes its previous-enable bit, and the previous-enable bit becomes 1.
  - `prv_out` becomes the level's previous-mode field (SPP zero-extended).
  - That field is cleared to user.
  - All other status bits are kept.
- R5: A legal user return clears UIE (bit 0) and UPIE (bit 4), keeps all other bits, and leaves `prv_out` at user.
- R6: A legal machine return with `ext_irq_pend`=1 raises `trap_req` with `trap_irq`=1 and cause 11. Without the flag, a legal return raises nothing.
- R7: The environment call sets `npc`=PC+4. It raises cause 11 in machine mode, cause 8 in user mode, and no request in supervisor or hypervisor mode.
- R8: The breakpoint sets `npc`=PC+4, pulses `brk_flag` and raises cause 3 with `trap_irq`=0.
- R9: Results appear one clock after the `in_valid` cycle. In a cycle after `in_valid` was low, `out_valid`, `sys_hit`, `trap_req`, `trap_irq` and `brk_flag` are 0, and `status_out`, `prv_out`, `npc`, `epc_addr` and `trap_cause` keep their values.
- R10: During and after reset, before the first accepted request, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | PC of the instruction |
| cur_prv | input | 2 | Current privilege |
| status_in | input | 13 | Current status register |
| epc_u | input | XLEN | Exception PC at 0x041 |
| epc_s | input | XLEN | Exception PC at 0x141 |
| epc_h | input | XLEN | Exception PC at 0x241 |
| epc_m | input | XLEN | Exception PC at 0x341 |
| ext_irq_pend | input | 1 | Machine external interrupt still pending |
| out_valid | output | 1 | Result present |
| sys_hit | output | 1 | Word was one of the six encodings |
| prv_out | output | 2 | New privilege |
| status_out | output | 13 | New status register |
| npc | output | XLEN | Next PC |
| epc_addr | output | 12 | CSR address of the exception PC used |
| trap_req | output | 1 | Exception or interrupt request |
| trap_irq | output | 1 | Request is an interrupt |
| trap_cause | output | 4 | Cause code |
| brk_flag | output | 1 | Breakpoint status pulse |

## Verification
The hardest case to reach is a return that meets a mismatched privilege while the status register holds a distinctive pattern. Only then does it show whether the illegal path truly leaves every field alone. The same applies to a legal return whose previous-mode field is non-zero, which is the only way to observe both the privilege change and the clearing of the field. The stimulus therefore crosses every return with every current privilege under several distinct status patterns, and then draws random words, privileges, statuses and interrupt flags. A behavioural model in the bench is compared against the outputs on every clock.

// File: rtl/tru_pkg.sv
package tru_pkg;
  localparam int STW       = 13;
  localparam int PIE_BASE  = 4;
  localparam int SPP_BIT   = 8;
  localparam int HPP_LO    = 9;
  localparam int MPP_LO    = 11;
  localparam int CW        = 4;

  typedef enum logic [1:0] {PRV_USR = 2'd0, PRV_SUP = 2'd1, PRV_HYP = 2'd2, PRV_MCH = 2'd3} prv_e;

  localparam logic [27:0] RET_LOW   = 28'h0200073;
  localparam logic [31:0] ECALL_ENC = 32'h00000073;
  localparam logic [31:0] EBRK_ENC  = 32'h00100073;

  localparam logic [CW-1:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [CW-1:0] CAUSE_BRK     = 4'd3;
  localparam logic [CW-1:0] CAUSE_CALL_U  = 4'd8;
  localparam logic [CW-1:0] CAUSE_CALL_M  = 4'd11;
  localparam logic [CW-1:0] CAUSE_MEXT    = 4'd11;

  function automatic logic [11:0] epc_csr_addr(input logic [1:0] lvl);
    return (12'(lvl) << 8) + 12'h041;
  endfunction

  function automatic logic [1:0] prev_mode(input logic [STW-1:0] st, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return {1'b0, st[SPP_BIT]};
      2'd2:    return st[HPP_LO+1:HPP_LO];
      2'd3:    return st[MPP_LO+1:MPP_LO];
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [STW-1:0] ret_status(input logic [STW-1:0] st, input logic [1:0] lvl);
    logic [STW-1:0] r;
    r = st;
    if (lvl == 2'd0) begin
      r[0]        = 1'b0;
      r[PIE_BASE] = 1'b0;
    end else begin
      r[int'(lvl)]            = st[PIE_BASE + int'(lvl)];
      r[PIE_BASE + int'(lvl)] = 1'b1;
      case (lvl)
        2'd1:    r[SPP_BIT] = 1'b0;
        2'd2:    r[HPP_LO+1:HPP_LO] = 2'd0;
        default: r[MPP_LO+1:MPP_LO] = 2'd0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tru_decode.sv
module tru_decode
  import tru_pkg::*;
(
  input  logic [31:0] instr,
  output logic        is_ret,
  output logic [1:0]  ret_lvl,
  output logic        is_ecall,
  output logic        is_ebrk
);
  always_comb begin
    is_ret   = (instr[31:30] == 2'b00) && (instr[27:0] == RET_LOW);
    ret_lvl  = instr[29:28];
    is_ecall = (instr == ECALL_ENC);
    is_ebrk  = (instr == EBRK_ENC);
  end
endmodule

// File: rtl/tru_epc_mux.sv
module tru_epc_mux
  import tru_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NLVL = 4
) (
  input  logic [NLVL-1:0][XLEN-1:0] epc_bank,
  input  logic [11:0]               addr,
  output logic [XLEN-1:0]           epc
);
  logic [NLVL-1:0][XLEN-1:0] masked;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign masked[g] = (addr == epc_csr_addr(2'(g))) ? epc_bank[g] : '0;
  end

  always_comb begin
    epc = '0;
    for (int i = 0; i < NLVL; i++) epc |= masked[i];
  end
endmodule

// File: rtl/tru_cause.sv
module tru_cause
  import tru_pkg::*;
(
  input  logic          ret_bad,
  input  logic          mret_irq,
  input  logic          is_ecall,
  input  logic          is_ebrk,
  input  logic [1:0]    cur_prv,
  output logic          req,
  output logic          irq,
  output logic [CW-1:0] cause
);
  always_comb begin
    req   = 1'b0;
    irq   = 1'b0;
    cause = '0;
    if (ret_bad) begin
      req   = 1'b1;
      cause = CAUSE_ILLEGAL;
    end else if (mret_irq) begin
      req   = 1'b1;
      irq   = 1'b1;
      cause = CAUSE_MEXT;
    end else if (is_ebrk) begin
      req   = 1'b1;
      cause = CAUSE_BRK;
    end else if (is_ecall) begin
      if (cur_prv == PRV_MCH) begin
        req   = 1'b1;
        cause = CAUSE_CALL_M;
      end else if (cur_prv == PRV_USR) begin
        req   = 1'b1;
        cause = CAUSE_CALL_U;
      end
    end
  end
endmodule

// File: rtl/sys_ret_trap_unit.sv
module sys_ret_trap_unit
  import tru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      cur_prv,
  input  logic [12:0]     status_in,
  input  logic [XLEN-1:0] epc_u,
  input  logic [XLEN-1:0] epc_s,
  input  logic [XLEN-1:0] epc_h,
  input  logic [XLEN-1:0] epc_m,
  input  logic            ext_irq_pend,
  output logic            out_valid,
  output logic            sys_hit,
  output logic [1:0]      prv_out,
  output logic [12:0]     status_out,
  output logic [XLEN-1:0] npc,
  output logic [11:0]     epc_addr,
  output logic            trap_req,
  output logic            trap_irq,
  output logic [3:0]      trap_cause,
  output logic            brk_flag
);
  localparam int NLVL = 4;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic        is_ret, is_ecall, is_ebrk;
  logic [1:0]  ret_lvl;
  logic        ret_ok, ret_bad, mret_irq, hit;
  logic [11:0] addr_c;
  logic [XLEN-1:0] epc_sel, npc_c;
  logic [STW-1:0]  status_c;
  logic [1:0]      prv_c;
  logic            req_c, irq_c;
  logic [CW-1:0]   cause_c;
  logic [NLVL-1:0][XLEN-1:0] epc_bank;

  assign epc_bank = {epc_m, epc_h, epc_s, epc_u};

  tru_decode u_dec (
    .instr(instr), .is_ret(is_ret), .ret_lvl(ret_lvl),
    .is_ecall(is_ecall), .is_ebrk(is_ebrk)
  );

  assign ret_ok   = is_ret && (ret_lvl == cur_prv);
  assign ret_bad  = is_ret && (ret_lvl != cur_prv);
  assign mret_irq = ret_ok && (ret_lvl == PRV_MCH) && ext_irq_pend;
  assign hit      = is_ret || is_ecall || is_ebrk;
  assign addr_c   = is_ret ? epc_csr_addr(ret_lvl) : 12'h000;

  tru_epc_mux #(.XLEN(XLEN), .NLVL(NLVL)) u_epc (
    .epc_bank(epc_bank), .addr(addr_c), .epc(epc_sel)
  );

  tru_cause u_cause (
    .ret_bad(ret_bad), .mret_irq(mret_irq), .is_ecall(is_ecall),
    .is_ebrk(is_ebrk), .cur_prv(cur_prv),
    .req(req_c), .irq(irq_c), .cause(cause_c)
  );

  always_comb begin
    status_c = status_in;
    prv_c    = cur_prv;
    npc_c    = pc + STEP;
    if (ret_bad) begin
      npc_c = pc;
    end else if (ret_ok) begin
      npc_c    = epc_sel;
      status_c = ret_status(status_in, ret_lvl);
      prv_c    = prev_mode(status_in, ret_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sys_hit    <= 1'b0;
      prv_out    <= 2'd0;
      status_out <= '0;
      npc        <= '0;
      epc_addr   <= '0;
      trap_req   <= 1'b0;
      trap_irq   <= 1'b0;
      trap_cause <= '0;
      brk_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      sys_hit   <= in_valid && hit;
      trap_req  <= in_valid && req_c;
      trap_irq  <= in_valid && irq_c;
      brk_flag  <= in_valid && is_ebrk;
      if (in_valid) begin
        prv_out    <= prv_c;
        status_out <= status_c;
        npc        <= npc_c;
        epc_addr   <= addr_c;
        trap_cause <= cause_c;
      end
    end
  end
endmodule

// File: rtl/tru_checker.sv
module tru_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [1:0]  cur_prv,
  input logic [12:0] status_in,
  input logic        ext_irq_pend,
  input logic        out_valid,
  input logic        sys_hit,
  input logic [1:0]  prv_out,
  input logic [12:0] status_out,
  input logic [11:0] epc_addr,
  input logic        trap_req,
  input logic        trap_irq,
  input logic [3:0]  trap_cause,
  input logic        brk_flag
);
  logic is_ret_w, ret_mismatch_w;
  assign is_ret_w       = (instr[31:30] == 2'b00) && (instr[27:0] == 28'h0200073);
  assign ret_mismatch_w = is_ret_w && (instr[29:28] != cur_prv);

  // R2
  illegal_ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ret_mismatch_w |=> trap_req && !trap_irq && trap_cause == 4'd2
      && status_out == $past(status_in) && prv_out == $past(cur_prv));

  // R3
  epc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_ret_w |=> epc_addr[7:0] == 8'h41 && epc_addr[9:8] == $past(instr[29:28]));

  // R4
  sret_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr == 32'h10200073 && cur_prv == 2'd1
      |=> status_out[5] && !status_out[8] && status_out[1] == $past(status_in[5]));

  // R6
  mret_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr == 32'h30200073 && cur_prv == 2'd3 && ext_irq_pend
      |=> trap_req && trap_irq && trap_cause == 4'd11 && prv_out == $past(status_in[12:11]));

  // R7
  ecall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr == 32'h00000073 && (cur_prv == 2'd1 || cur_prv == 2'd2) |=> !trap_req);

  // R8
  brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> trap_req && !trap_irq && trap_cause == 4'd3 && sys_hit);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !trap_req && !trap_irq && !brk_flag && !sys_hit
      && $stable(status_out) && $stable(prv_out));

  // R9
  irq_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_irq |-> trap_req && out_valid);
endmodule

bind sys_ret_trap_unit tru_checker u_tru_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cur_prv(cur_prv),
  .status_in(status_in), .ext_irq_pend(ext_irq_pend), .out_valid(out_valid),
  .sys_hit(sys_hit), .prv_out(prv_out), .status_out(status_out), .epc_addr(epc_addr),
  .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause), .brk_flag(brk_flag)
);

// File: tb/tb_sys_ret_trap_unit.sv
module tb_sys_ret_trap_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] pc = '0;
  logic [1:0]      cur_prv = '0;
  logic [12:0]     status_in = '0;
  logic [XLEN-1:0] epc_u = 64'h1000, epc_s = 64'h2000, epc_h = 64'h3000, epc_m = 64'h4000;
  logic            ext_irq_pend = 1'b0;
  logic            out_valid, sys_hit, trap_req, trap_irq, brk_flag;
  logic [1:0]      prv_out;
  logic [12:0]     status_out;
  logic [XLEN-1:0] npc;
  logic [11:0]     epc_addr;
  logic [3:0]      trap_cause;

  sys_ret_trap_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .cur_prv(cur_prv), .status_in(status_in), .epc_u(epc_u), .epc_s(epc_s),
    .epc_h(epc_h), .epc_m(epc_m), .ext_irq_pend(ext_irq_pend),
    .out_valid(out_valid), .sys_hit(sys_hit), .prv_out(prv_out),
    .status_out(status_out), .npc(npc), .epc_addr(epc_addr), .trap_req(trap_req),
    .trap_irq(trap_irq), .trap_cause(trap_cause), .brk_flag(brk_flag)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // expected state of the model
  logic        e_valid = 0, e_hit = 0, e_req = 0, e_irq = 0, e_brk = 0;
  logic [1:0]  e_prv = 0;
  logic [12:0] e_st = 0;
  logic [XLEN-1:0] e_npc = 0;
  logic [11:0] e_addr = 0;
  logic [3:0]  e_cause = 0;
  string       e_tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid = 0; e_hit = 0; e_req = 0; e_irq = 0; e_brk = 0;
      e_prv = 0; e_st = 0; e_npc = 0; e_addr = 0; e_cause = 0; e_tag = "R10";
    end else if (!in_valid) begin
      e_valid = 0; e_hit = 0; e_req = 0; e_irq = 0; e_brk = 0; e_tag = "R9";
    end else begin
      int lvl;
      e_valid = 1; e_hit = 0; e_req = 0; e_irq = 0; e_brk = 0; e_cause = 0;
      e_prv = cur_prv; e_st = status_in; e_npc = pc + 4; e_addr = 0; e_tag = "R1";
      if (instr == 32'h00200073 || instr == 32'h10200073 ||
          instr == 32'h20200073 || instr == 32'h30200073) begin
        lvl = int'(instr >> 28);
        e_hit = 1;
        e_addr = 12'(lvl * 256 + 65);
        if (lvl != int'(cur_prv)) begin
          e_req = 1; e_cause = 2; e_npc = pc; e_tag = "R2";
        end else begin
          e_npc = (lvl == 0) ? epc_u : (lvl == 1) ? epc_s : (lvl == 2) ? epc_h : epc_m;
          if (lvl == 0) begin
            e_st[0] = 0; e_st[4] = 0; e_prv = 0; e_tag = "R5";
          end else begin
            e_st[lvl] = status_in[lvl + 4];
            e_st[lvl + 4] = 1;
            e_tag = "R4";
            if (lvl == 1) begin e_prv = {1'b0, status_in[8]}; e_st[8] = 0; end
            else if (lvl == 2) begin e_prv = status_in[10:9]; e_st[10:9] = 0; end
            else begin
              e_prv = status_in[12:11]; e_st[12:11] = 0;
              if (ext_irq_pend) begin e_req = 1; e_irq = 1; e_cause = 11; e_tag = "R6"; end
            end
          end
        end
      end else if (instr == 32'h00000073) begin
        e_hit = 1; e_tag = "R7";
        if (cur_prv == 3) begin e_req = 1; e_cause = 11; end
        else if (cur_prv == 0) begin e_req = 1; e_cause = 8; end
      end else if (instr == 32'h00100073) begin
        e_hit = 1; e_req = 1; e_cause = 3; e_brk = 1; e_tag = "R8";
      end
    end
  end

  task automatic cmp(string name, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", e_tag, name, act, exp, $time);
    end
  endtask

  bit running = 1;
  always @(negedge clk) if (running) begin
    cmp("out_valid", 64'(out_valid), 64'(e_valid));
    cmp("sys_hit", 64'(sys_hit), 64'(e_hit));
    cmp("trap_req", 64'(trap_req), 64'(e_req));
    cmp("trap_irq", 64'(trap_irq), 64'(e_irq));
    cmp("brk_flag", 64'(brk_flag), 64'(e_brk));
    cmp("prv_out", 64'(prv_out), 64'(e_prv));
    cmp("status_out", 64'(status_out), 64'(e_st));
    cmp("npc", npc, e_npc);
    cmp("epc_addr", 64'(epc_addr), 64'(e_addr));
    cmp("trap_cause", 64'(trap_cause), 64'(e_cause));
  end

  task automatic issue(logic [31:0] w, logic [1:0] p, logic [12:0] st, logic irq);
    @(negedge clk);
    in_valid = 1; instr = w; cur_prv = p; status_in = st; ext_irq_pend = irq;
    pc = pc + 64'h40;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; instr = $urandom; status_in = 13'($urandom);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] words [8];
    logic [12:0] pats [4];
    words[0] = 32'h00200073; words[1] = 32'h10200073; words[2] = 32'h20200073;
    words[3] = 32'h30200073; words[4] = 32'h00000073; words[5] = 32'h00100073;
    words[6] = 32'h00300073; words[7] = 32'h40200073;
    pats[0] = 13'h1FFF; pats[1] = 13'h0000; pats[2] = 13'h1AF0; pats[3] = 13'h050F;
    // R10: reset state observed for several cycles
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: unrecognised words
    issue(32'h00000013, 2'd3, 13'h0ABC, 0);
    issue(32'h40200073, 2'd0, 13'h1234, 1);
    idle();
    // R2 R3 R4 R5: every return at every privilege with several patterns
    for (int w = 0; w < 4; w++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++) issue(words[w], 2'(p), pats[s], s[0]);
    // R6: machine return with and without pending interrupt
    issue(32'h30200073, 2'd3, 13'h1880, 1);
    issue(32'h30200073, 2'd3, 13'h1880, 0);
    idle();
    // R7: environment call at every level
    for (int p = 0; p < 4; p++) issue(32'h00000073, 2'(p), 13'h0F0F, 1);
    // R8: breakpoint
    issue(32'h00100073, 2'd1, 13'h0333, 0);
    idle(); idle();
    // R9: mixed random traffic with idle gaps
    for (int i = 0; i < 400; i++) begin
      epc_u = {$urandom, $urandom}; epc_s = {$urandom, $urandom};
      epc_h = {$urandom, $urandom}; epc_m = {$urandom, $urandom};
      if ($urandom_range(0, 4) == 0) idle();
      else issue(words[$urandom_range(0, 7)], 2'($urandom), 13'($urandom), 1'($urandom));
    end
    idle(); idle();
    @(posedge clk);
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule